// File: doc/BRIEF.md
# Predicate Register File with Slot Nullification

This block holds the one-bit condition flags that let a statically scheduled, wide-issue core replace hard-to-predict branches with guarded execution. A compare operation, evaluated elsewhere, delivers a single result bit and two destination indices. The block stores the result in the first destination and its inverse in the second, so the instructions on both sides of a condition can each name the flag that enables them.

Every instruction slot issued in a cycle carries a guard index. The block reads the flag selected by that index and produces a commit enable for the slot. When the guard flag is false, the slot's register-file write and memory write are both forced low, so the instruction behaves as a no-op. Flag 0 always reads true, which gives unguarded instructions a fixed enable. Flags are stored in registers, so a compare changes what the guards read one cycle later.

Top module: `pred_nullify_unit`

## Requirements
- R1: The file holds 64 one-bit flags addressed by 6-bit indices. After reset, every flag except index 0 reads false.
- R2: Index 0 always reads true. A compare write aimed at index 0 is dropped, and the other destination of that compare is still written.
- R3: On a cycle with `cmp_valid_i` high and distinct destinations, the flag at `cmp_dst_a_i` takes `cmp_result_i` and the flag at `cmp_dst_b_i` takes its inverse. Both values are visible to guard reads from the next cycle on.
- R4: A compare does not change the value a guard read returns in the same cycle as that compare.
- R5: When `cmp_valid_i` is high and both destinations are equal, `cmp_illegal_o` is high in that cycle and no flag changes.
- R6: While `cmp_valid_i` is low, no flag changes, whatever the destination and result inputs hold.
- R7: For each of the 3 slots, `slot_en_o[i]` is high exactly when `slot_valid_i[i]` is high and the flag at the slot's guard index reads true. Slot i's index is `slot_qp_i[6*i+5:6*i]`, and the slots are independent of each other.
- R8: `slot_rf_we_o[i]` equals `slot_rf_we_i[i]` and `slot_mem_we_o[i]` equals `slot_mem_we_i[i]` when the slot is enabled. Both are low when the slot is nullified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | A compare result is present this cycle |
| cmp_result_i | input | 1 | Compare outcome, written to destination A |
| cmp_dst_a_i | input | 6 | Index that takes the outcome |
| cmp_dst_b_i | input | 6 | Index that takes the inverted outcome |
| cmp_illegal_o | output | 1 | Both destinations match; the write is dropped |
| slot_valid_i | input | 3 | Slot holds an issued instruction |
| slot_qp_i | input | 18 | Guard index per slot, 6 bits each, slot 0 in the low bits |
| slot_rf_we_i | input | 3 | Register write request per slot |
| slot_mem_we_i | input | 3 | Memory write request per slot |
| slot_en_o | output | 3 | Commit enable per slot |
| slot_rf_we_o | output | 3 | Gated register write enable |
| slot_mem_we_o | output | 3 | Gated memory write enable |

## Verification
On every cycle, the assertions check the following: index 0 enables a valid slot; an idle or illegal compare leaves the whole file unchanged; a legal compare lands its value and its inverse in the named flags one cycle later; and no gated write enable is raised without both the request and the slot enable. Other properties depend on sequences of operations, so only the bench scenarios show them. These are the reset contents, guard reads in the same cycle as a compare, a dropped write to index 0 that still writes its partner, and overwrite order across successive compares.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned PRED_COUNT = 64;
  localparam int unsigned SLOT_COUNT = 3;

  typedef struct packed {
    logic valid;
    logic result;
    logic [$clog2(PRED_COUNT)-1:0] dst_a;
    logic [$clog2(PRED_COUNT)-1:0] dst_b;
  } cmp_req_t;
endpackage

// File: rtl/pred_regfile.sv
module pred_regfile #(
  parameter int unsigned NUM_PREDS = 64,
  parameter int unsigned NUM_READS = 3,
  localparam int unsigned IDX_W = $clog2(NUM_PREDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  pred_pkg::cmp_req_t         wr_req_i,
  output logic                       wr_illegal_o,
  input  logic [NUM_READS*IDX_W-1:0] rd_idx_i,
  output logic [NUM_READS-1:0]       rd_val_o
);
  logic [NUM_PREDS-1:1] pred_q;
  logic [NUM_PREDS-1:0] pred_all;
  logic                 wr_ok;

  assign wr_illegal_o = wr_req_i.valid && (wr_req_i.dst_a == wr_req_i.dst_b);
  assign wr_ok        = wr_req_i.valid && !wr_illegal_o;
  assign pred_all     = {pred_q, 1'b1};  // index 0 fixed true

  for (genvar g = 1; g < NUM_PREDS; g++) begin : g_reg
    logic hit_a, hit_b;
    assign hit_a = wr_ok && (wr_req_i.dst_a == IDX_W'(g));
    assign hit_b = wr_ok && (wr_req_i.dst_b == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    pred_q[g] <= 1'b0;
      else if (hit_a) pred_q[g] <= wr_req_i.result;
      else if (hit_b) pred_q[g] <= ~wr_req_i.result;
    end
  end

  for (genvar r = 0; r < NUM_READS; r++) begin : g_rd
    assign rd_val_o[r] = pred_all[rd_idx_i[r*IDX_W +: IDX_W]];
  end

  assert_illegal_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o |=> $stable(pred_q));

  assert_idle_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i.valid |=> $stable(pred_q));

  assert_dst_a_written_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_req_i.dst_a != '0) |=> pred_all[$past(wr_req_i.dst_a)] == $past(wr_req_i.result));

  assert_dst_b_inverted_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && wr_req_i.dst_b != '0) |=> pred_all[$past(wr_req_i.dst_b)] == !$past(wr_req_i.result));
endmodule

// File: rtl/pred_slot_gate.sv
module pred_slot_gate (
  input  logic valid_i,
  input  logic guard_i,
  input  logic rf_we_i,
  input  logic mem_we_i,
  output logic en_o,
  output logic rf_we_o,
  output logic mem_we_o
);
  assign en_o     = valid_i && guard_i;
  assign rf_we_o  = en_o && rf_we_i;
  assign mem_we_o = en_o && mem_we_i;
endmodule

// File: rtl/pred_nullify_unit.sv
module pred_nullify_unit #(
  parameter int unsigned NUM_PREDS = pred_pkg::PRED_COUNT,
  parameter int unsigned NUM_SLOTS = pred_pkg::SLOT_COUNT,
  localparam int unsigned IDX_W = $clog2(NUM_PREDS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmp_valid_i,
  input  logic                       cmp_result_i,
  input  logic [IDX_W-1:0]           cmp_dst_a_i,
  input  logic [IDX_W-1:0]           cmp_dst_b_i,
  output logic                       cmp_illegal_o,
  input  logic [NUM_SLOTS-1:0]       slot_valid_i,
  input  logic [NUM_SLOTS*IDX_W-1:0] slot_qp_i,
  input  logic [NUM_SLOTS-1:0]       slot_rf_we_i,
  input  logic [NUM_SLOTS-1:0]       slot_mem_we_i,
  output logic [NUM_SLOTS-1:0]       slot_en_o,
  output logic [NUM_SLOTS-1:0]       slot_rf_we_o,
  output logic [NUM_SLOTS-1:0]       slot_mem_we_o
);
  pred_pkg::cmp_req_t    cmp_req;
  logic [NUM_SLOTS-1:0]  guard_val;

  assign cmp_req = '{valid: cmp_valid_i, result: cmp_result_i,
                     dst_a: cmp_dst_a_i, dst_b: cmp_dst_b_i};

  pred_regfile #(.NUM_PREDS(NUM_PREDS), .NUM_READS(NUM_SLOTS)) u_file (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_req_i     (cmp_req),
    .wr_illegal_o (cmp_illegal_o),
    .rd_idx_i     (slot_qp_i),
    .rd_val_o     (guard_val)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    pred_slot_gate u_gate (
      .valid_i  (slot_valid_i[s]),
      .guard_i  (guard_val[s]),
      .rf_we_i  (slot_rf_we_i[s]),
      .mem_we_i (slot_mem_we_i[s]),
      .en_o     (slot_en_o[s]),
      .rf_we_o  (slot_rf_we_o[s]),
      .mem_we_o (slot_mem_we_o[s])
    );

    assert_p0_enables_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_valid_i[s] && slot_qp_i[s*IDX_W +: IDX_W] == '0) |-> slot_en_o[s]);

    assert_invalid_slot_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_valid_i[s] |-> !slot_en_o[s]);

    assert_rf_we_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_rf_we_o[s] |-> (slot_rf_we_i[s] && slot_en_o[s]));

    assert_mem_we_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_mem_we_o[s] |-> (slot_mem_we_i[s] && slot_en_o[s]));
  end
endmodule

// File: tb/pred_nullify_unit_tb.sv
module pred_nullify_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_valid = 1'b0, cmp_result = 1'b0;
  logic [5:0]  cmp_a = '0, cmp_b = '0;
  logic        cmp_illegal;
  logic [2:0]  s_valid = '0, s_rf = '0, s_mem = '0;
  logic [17:0] s_qp = '0;
  logic [2:0]  s_en, s_rf_o, s_mem_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pred_nullify_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmp_valid_i(cmp_valid), .cmp_result_i(cmp_result),
    .cmp_dst_a_i(cmp_a), .cmp_dst_b_i(cmp_b), .cmp_illegal_o(cmp_illegal),
    .slot_valid_i(s_valid), .slot_qp_i(s_qp),
    .slot_rf_we_i(s_rf), .slot_mem_we_i(s_mem),
    .slot_en_o(s_en), .slot_rf_we_o(s_rf_o), .slot_mem_we_o(s_mem_o)
  );

  // {result, dst_a, dst_b, qp0, qp1, qp2, expected enables [2:0], expected illegal}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 6'd5,  6'd6,  6'd5,  6'd6,  6'd0,  3'b101, 1'b0},
    {1'b0, 6'd5,  6'd7,  6'd5,  6'd7,  6'd6,  3'b010, 1'b0},
    {1'b1, 6'd0,  6'd9,  6'd0,  6'd9,  6'd63, 3'b001, 1'b0},
    {1'b1, 6'd63, 6'd0,  6'd63, 6'd0,  6'd1,  3'b011, 1'b0},
    {1'b1, 6'd10, 6'd10, 6'd10, 6'd10, 6'd7,  3'b100, 1'b1},
    {1'b0, 6'd1,  6'd2,  6'd2,  6'd1,  6'd63, 3'b101, 1'b0},
    {1'b1, 6'd2,  6'd1,  6'd1,  6'd2,  6'd5,  3'b010, 1'b0},
    {1'b0, 6'd0,  6'd0,  6'd0,  6'd0,  6'd0,  3'b111, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_slots(input logic [5:0] q0, q1, q2, input logic [2:0] v,
                            input logic [2:0] rf, input logic [2:0] mem);
    s_qp = {q2, q1, q0}; s_valid = v; s_rf = rf; s_mem = mem;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents: p0 true, others false
    read_slots(6'd0, 6'd1, 6'd63, 3'b111, 3'b111, 3'b111);
    check(s_en == 3'b001, "R1 reset state", s_en, 3'b001);

    // table walk: R3, R2, R5, R7, R8
    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      @(negedge clk);
      s_valid = '0;
      cmp_valid = 1'b1; cmp_result = v[34]; cmp_a = v[33:28]; cmp_b = v[27:22];
      #1;
      check(cmp_illegal == v[0], "R5 illegal flag", cmp_illegal, v[0]);
      @(negedge clk);
      cmp_valid = 1'b0;
      read_slots(v[21:16], v[15:10], v[9:4], 3'b111, 3'b111, 3'b111);
      check(s_en == v[3:1], "R3 R7 guard enables", s_en, v[3:1]);
      check(s_rf_o == v[3:1] && s_mem_o == v[3:1], "R8 gated write enables",
            {s_rf_o, s_mem_o}, {v[3:1], v[3:1]});
    end

    // R6: idle compare inputs do nothing (p20 stays 0, p21 stays 0)
    @(negedge clk);
    s_valid = '0;
    cmp_valid = 1'b0; cmp_result = 1'b1; cmp_a = 6'd20; cmp_b = 6'd21;
    @(negedge clk);
    read_slots(6'd20, 6'd21, 6'd0, 3'b111, 3'b111, 3'b111);
    check(s_en == 3'b100, "R6 idle compare ignored", s_en, 3'b100);

    // R4: same-cycle read sees old value; next cycle sees new
    @(negedge clk);
    cmp_valid = 1'b1; cmp_result = 1'b1; cmp_a = 6'd20; cmp_b = 6'd21;
    read_slots(6'd20, 6'd21, 6'd0, 3'b111, 3'b111, 3'b111);
    check(s_en == 3'b100, "R4 no same-cycle visibility", s_en, 3'b100);
    @(negedge clk);
    cmp_valid = 1'b0;
    read_slots(6'd20, 6'd21, 6'd0, 3'b111, 3'b111, 3'b111);
    check(s_en == 3'b101, "R4 visible next cycle", s_en, 3'b101);

    // R7: invalid slot with true guard is off
    read_slots(6'd20, 6'd0, 6'd20, 3'b010, 3'b111, 3'b111);
    check(s_en == 3'b010, "R7 slot valid gating", s_en, 3'b010);

    // R8: per-slot write requests pass only when enabled
    read_slots(6'd20, 6'd21, 6'd0, 3'b111, 3'b011, 3'b110);
    check(s_rf_o == 3'b001, "R8 rf enable pass", s_rf_o, 3'b001);
    check(s_mem_o == 3'b100, "R8 mem enable pass", s_mem_o, 3'b100);

    // R2: guard 0 true with writes aimed at it; R1 after re-reset
    read_slots(6'd0, 6'd0, 6'd0, 3'b111, 3'b000, 3'b000);
    check(s_en == 3'b111, "R2 index zero true", s_en, 3'b111);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    read_slots(6'd20, 6'd63, 6'd2, 3'b111, 3'b111, 3'b111);
    check(s_en == 3'b000, "R1 reset clears flags", s_en, 3'b000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule